// File: doc/BRIEF.md
# ADC Serial Command and Readout Port

This block is the digital side of a 14-bit multichannel sampling converter's serial port. A host drives a chip-select, a serial clock and a data input. The port takes in an 8-bit command word and picks an input channel. It then runs acquisition and conversion and shifts the result back out, most significant bit first. The quantizer itself is outside the block. A parallel result bus stands in for it, and the port raises acquire and convert strobes that the analog side would follow.

Two timing modes exist, and the last command bit selects between them. In serial-clock mode the host keeps clocking: eight command clocks, four acquisition clocks, four conversion clocks and sixteen result clocks, which makes 32 clocks in all. In local-clock mode the host stops its clock after the command. A local oscillator then starts after a fixed delay, paces acquisition and conversion, and signals completion by pulling the active-low end-of-conversion output low. The host then clocks the result out. Raising chip-select at any point abandons the transaction and returns the port to shutdown.

All host pins are brought into the system clock domain through a synchronizer. Edges are detected on the synchronized copies. The tri-state data pin is modelled as a data bit plus an output-enable.

Top module: `adcsp_port`

## Requirements
- R1: After reset, dout_oe is 0, eoc_n is 1, acq and conv are 0, and dout is 0.
- R2: A valid falling edge of cs_n makes dout_oe 1 with dout at 0 until result bits are shifted out.
- R3: The command is taken from din on the first eight sclk rising edges, most significant bit first. Bit 0, the 8th bit, selects local-clock mode when 1 and serial-clock mode when 0.
- R4: The channel field is command bits 7:5, the first three bits sent. It is committed to ch_sel on the 3rd sclk rising edge, before the 4th, and holds at all other times.
- R5: In serial-clock mode, acq is high from the 8th to the 12th rising edge and conv is high from the 12th to the 16th. A transaction is 32 sclk cycles long.
- R6: The 16-bit output frame is the 14-bit result followed by two zero bits. It is driven most significant bit first, changing on sclk falling edges, for the host to sample on rising edges.
- R7: Once the 16 frame bits are out, further sclk falling edges before cs_n rises shift out 0.
- R8: In local-clock mode, the oscillator starts START_DLY system cycles after the 8th rising edge. acq runs from its 2nd rising edge to the falling edge of its 6th cycle, and conv then lasts INT_CONV oscillator cycles. At that point eoc_n falls and the frame's MSB appears on dout.
- R9: cs_n going high during acquisition or conversion drops acq and conv at once and keeps eoc_n high. The port stays in shutdown until the next valid cs_n fall.
- R10: A cs_n fall that comes fewer than MIN_CSH system cycles after cs_n rose is ignored, and csh_viol pulses for one cycle.
- R11: dout_oe is 0 whenever the synchronized cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip-select, active low |
| sclk | input | 1 | Host serial clock |
| din | input | 1 | Host command data |
| conv_data | input | RES_W | Quantizer result stand-in |
| dout | output | 1 | Serial result bit |
| dout_oe | output | 1 | Output enable for dout |
| eoc_n | output | 1 | End of conversion, active low |
| acq | output | 1 | Acquisition strobe |
| conv | output | 1 | Conversion strobe |
| ch_sel | output | CH_W | Selected channel |
| csh_viol | output | 1 | Pulse on an ignored early cs_n fall |

## Verification
The bench builds the port with START_DLY=6, OSC_HALF=2, MIN_CSH=16 and a two-stage synchronizer, which keeps a whole local-clock conversion under a hundred system cycles. That short length makes it practical to measure the time to the eoc_n fall against a computed window, and to abort in the middle of a conversion at a known point. It also lets a chip-select gap of three cycles fall clearly inside the minimum-high window, while a forty-cycle gap falls clearly outside it.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;
  typedef enum logic [2:0] {
    ST_SHDN,
    ST_CMD,
    ST_XACQ,
    ST_XCONV,
    ST_IRUN,
    ST_OUT
  } port_st_e;
endpackage

// File: rtl/adcsp_sync.sv
module adcsp_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/adcsp_osc.sv
module adcsp_osc #(
  parameter int START_DLY = 12,
  parameter int HALF = 4,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic          rise_o,
  output logic          fall_o,
  output logic [IW-1:0] idx_o
);
  localparam int DW = $clog2(START_DLY + 1) < 1 ? 1 : $clog2(START_DLY + 1);
  localparam int HW = $clog2(HALF + 1) < 1 ? 1 : $clog2(HALF + 1);

  logic [DW-1:0] dly_q, dly_d;
  logic [HW-1:0] ph_q, ph_d;
  logic          iclk_q, iclk_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          rise_d, fall_d;

  always_comb begin
    dly_d  = dly_q;
    ph_d   = ph_q;
    iclk_d = iclk_q;
    idx_d  = idx_q;
    rise_d = 1'b0;
    fall_d = 1'b0;
    if (!run) begin
      dly_d  = '0;
      ph_d   = '0;
      iclk_d = 1'b0;
      idx_d  = '0;
    end else if (dly_q != DW'(START_DLY)) begin
      dly_d = dly_q + 1'b1;
    end else if (ph_q == HW'(HALF - 1)) begin
      ph_d   = '0;
      iclk_d = ~iclk_q;
      if (!iclk_q) begin
        rise_d = 1'b1;
        idx_d  = idx_q + 1'b1;
      end else begin
        fall_d = 1'b1;
      end
    end else begin
      ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q  <= '0;
      ph_q   <= '0;
      iclk_q <= 1'b0;
      idx_q  <= '0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      dly_q  <= dly_d;
      ph_q   <= ph_d;
      iclk_q <= iclk_d;
      idx_q  <= idx_d;
      rise_o <= rise_d;
      fall_o <= fall_d;
    end
  end

  assign idx_o = idx_q;

  // R8
  osc_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

  // R8
  osc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !rise_o && !fall_o);
endmodule

// File: rtl/adcsp_shift.sv
module adcsp_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic         load_drive,
  input  logic         shift,
  input  logic [W-1:0] frame_i,
  output logic         bit_o
);
  logic [W-1:0] sreg_q, sreg_d;
  logic         bit_q, bit_d;

  always_comb begin
    sreg_d = sreg_q;
    bit_d  = bit_q;
    if (clr) begin
      sreg_d = '0;
      bit_d  = 1'b0;
    end else if (load) begin
      if (load_drive) begin
        bit_d  = frame_i[W-1];
        sreg_d = frame_i << 1;
      end else begin
        sreg_d = frame_i;
      end
    end else if (shift) begin
      bit_d  = sreg_q[W-1];
      sreg_d = sreg_q << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      bit_q  <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      bit_q  <= bit_d;
    end
  end

  assign bit_o = bit_q;

  // R11
  clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !bit_o);
endmodule

// File: rtl/adcsp_port.sv
module adcsp_port
  import adcsp_pkg::*;
#(
  parameter int RES_W = 14,
  parameter int FRAME_W = 16,
  parameter int CMD_W = 8,
  parameter int CH_W = 3,
  parameter int EXT_ACQ = 4,
  parameter int EXT_CONV = 4,
  parameter int START_DLY = 12,
  parameter int OSC_HALF = 4,
  parameter int INT_CONV = 14,
  parameter int MIN_CSH = 32,
  parameter int SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  input  logic [RES_W-1:0] conv_data,
  output logic             dout,
  output logic             dout_oe,
  output logic             eoc_n,
  output logic             acq,
  output logic             conv,
  output logic [CH_W-1:0]  ch_sel,
  output logic             csh_viol
);
  localparam int PAD = FRAME_W - RES_W;
  localparam int EW = $clog2(CMD_W + EXT_ACQ + EXT_CONV + 1);
  localparam int IACQ_ON = 2;
  localparam int IACQ_OFF = 6;
  localparam int IW = $clog2(IACQ_OFF + INT_CONV + 2);
  localparam int CW = $clog2(MIN_CSH + 1);

  logic [2:0] raw, syn;
  logic       cs_s, sclk_s, din_s;
  logic       cs_q, sclk_q;
  logic       cs_fall, sclk_rise, sclk_fall;

  port_st_e        st_q, st_d;
  logic [EW-1:0]   ecnt_q, ecnt_d;
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic            acq_q, acq_d, conv_q, conv_d, eoc_q, eoc_d, viol_d;
  logic [CW-1:0]   csh_q, csh_d;
  logic            clr, load, load_drive, shift;
  logic            o_rise, o_fall;
  logic [IW-1:0]   o_idx;

  assign raw = {cs_n, sclk, din};
  adcsp_sync #(.W(3), .STAGES(SYNC), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );
  assign {cs_s, sclk_s, din_s} = syn;

  assign cs_fall   = cs_q & ~cs_s;
  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;

  adcsp_osc #(.START_DLY(START_DLY), .HALF(OSC_HALF), .IW(IW)) u_osc (
    .clk(clk), .rst_n(rst_n), .run(st_q == ST_IRUN),
    .rise_o(o_rise), .fall_o(o_fall), .idx_o(o_idx)
  );

  adcsp_shift #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .load_drive(load_drive),
    .shift(shift), .frame_i({conv_data, {PAD{1'b0}}}), .bit_o(dout)
  );

  // minimum chip-select high time
  always_comb begin
    csh_d = csh_q;
    if (cs_s) begin
      if (!cs_q)                      csh_d = CW'(1);
      else if (csh_q != CW'(MIN_CSH)) csh_d = csh_q + 1'b1;
    end
  end

  always_comb begin
    st_d       = st_q;
    ecnt_d     = ecnt_q;
    cmd_d      = cmd_q;
    ch_d       = ch_q;
    acq_d      = acq_q;
    conv_d     = conv_q;
    eoc_d      = eoc_q;
    viol_d     = 1'b0;
    clr        = 1'b0;
    load       = 1'b0;
    load_drive = 1'b0;
    shift      = 1'b0;
    if (cs_s) begin
      st_d   = ST_SHDN;
      acq_d  = 1'b0;
      conv_d = 1'b0;
      eoc_d  = 1'b1;
      clr    = 1'b1;
    end else begin
      unique case (st_q)
        ST_SHDN: if (cs_fall) begin
          if (csh_q == CW'(MIN_CSH)) begin
            st_d   = ST_CMD;
            ecnt_d = '0;
          end else begin
            viol_d = 1'b1;
          end
        end
        ST_CMD: if (sclk_rise) begin
          cmd_d  = {cmd_q[CMD_W-2:0], din_s};
          ecnt_d = ecnt_q + 1'b1;
          if (ecnt_q == EW'(CH_W - 1)) ch_d = {cmd_q[CH_W-2:0], din_s};
          if (ecnt_q == EW'(CMD_W - 1)) begin
            ecnt_d = '0;
            if (din_s) begin
              st_d = ST_IRUN;
            end else begin
              st_d  = ST_XACQ;
              acq_d = 1'b1;
            end
          end
        end
        ST_XACQ: if (sclk_rise) begin
          ecnt_d = ecnt_q + 1'b1;
          if (ecnt_q == EW'(EXT_ACQ - 1)) begin
            ecnt_d = '0;
            acq_d  = 1'b0;
            conv_d = 1'b1;
            st_d   = ST_XCONV;
          end
        end
        ST_XCONV: if (sclk_rise) begin
          ecnt_d = ecnt_q + 1'b1;
          if (ecnt_q == EW'(EXT_CONV - 1)) begin
            conv_d = 1'b0;
            load   = 1'b1;
            st_d   = ST_OUT;
          end
        end
        ST_IRUN: begin
          if (o_rise && o_idx == IW'(IACQ_ON)) acq_d = 1'b1;
          if (o_fall && o_idx == IW'(IACQ_OFF)) begin
            acq_d  = 1'b0;
            conv_d = 1'b1;
          end
          if (o_fall && o_idx == IW'(IACQ_OFF + INT_CONV)) begin
            conv_d     = 1'b0;
            eoc_d      = 1'b0;
            load       = 1'b1;
            load_drive = 1'b1;
            st_d       = ST_OUT;
          end
        end
        ST_OUT: shift = sclk_fall;
        default: st_d = ST_SHDN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      sclk_q   <= 1'b0;
      st_q     <= ST_SHDN;
      ecnt_q   <= '0;
      cmd_q    <= '0;
      ch_q     <= '0;
      acq_q    <= 1'b0;
      conv_q   <= 1'b0;
      eoc_q    <= 1'b1;
      csh_viol <= 1'b0;
      csh_q    <= CW'(MIN_CSH);
    end else begin
      cs_q     <= cs_s;
      sclk_q   <= sclk_s;
      st_q     <= st_d;
      ecnt_q   <= ecnt_d;
      cmd_q    <= cmd_d;
      ch_q     <= ch_d;
      acq_q    <= acq_d;
      conv_q   <= conv_d;
      eoc_q    <= eoc_d;
      csh_viol <= viol_d;
      csh_q    <= csh_d;
    end
  end

  assign dout_oe = (st_q != ST_SHDN);
  assign eoc_n   = eoc_q;
  assign acq     = acq_q;
  assign conv    = conv_q;
  assign ch_sel  = ch_q;

  // R11
  cs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !dout_oe);

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !acq && !conv && eoc_n);

  // R5
  acq_conv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acq && conv));

  // R10
  csh_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csh_viol |-> !dout_oe);

  // R4
  ch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(ch_sel));

  // R8
  eoc_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc_n) |-> dout_oe && !conv && !acq);
endmodule

// File: tb/adcsp_port_test.sv
`timescale 1ns/1ps
module adcsp_port_test;
  localparam int RES_W = 14;
  localparam int CH_W = 3;
  localparam int START_DLY = 6;
  localparam int OSC_HALF = 2;
  localparam int INT_CONV = 14;
  localparam int MIN_CSH = 16;
  localparam int SYNC = 2;
  localparam int H = 6;
  localparam int NV = 6;

  // {channel, mode, result, expected frame}
  localparam logic [33:0] VEC [NV] = '{
    {3'd5, 1'b0, 14'h2AB5, 16'hAAD4},
    {3'd2, 1'b1, 14'h3FFF, 16'hFFFC},
    {3'd7, 1'b0, 14'h0001, 16'h0004},
    {3'd0, 1'b1, 14'h2000, 16'h8000},
    {3'd6, 1'b1, 14'h1555, 16'h5554},
    {3'd1, 1'b0, 14'h0000, 16'h0000}
  };

  logic clk, rst_n, cs_n, sclk, din;
  logic [RES_W-1:0] conv_data;
  logic dout, dout_oe, eoc_n, acq, conv, csh_viol;
  logic [CH_W-1:0] ch_sel;

  int checks, errs, viol_cnt;
  bit done;

  adcsp_port #(
    .START_DLY(START_DLY), .OSC_HALF(OSC_HALF), .INT_CONV(INT_CONV),
    .MIN_CSH(MIN_CSH), .SYNC(SYNC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .conv_data(conv_data), .dout(dout), .dout_oe(dout_oe), .eoc_n(eoc_n),
    .acq(acq), .conv(conv), .ch_sel(ch_sel), .csh_viol(csh_viol)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) if (rst_n && csh_viol) viol_cnt <= viol_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_cycle(input logic b);
    din = b; sclk = 1'b0; wait_n(H);
    sclk = 1'b1; wait_n(H);
  endtask

  task automatic send_cmd(input logic [2:0] ch, input logic mode);
    logic [7:0] cmd;
    cmd = {ch, 4'b0000, mode};
    for (int i = 0; i < 8; i++) begin
      sclk_cycle(cmd[7-i]);
      if (i == 2) chk("R4 channel after 3rd edge", ch_sel, ch);
    end
  endtask

  task automatic run_txn(input logic [33:0] v);
    logic [2:0] ch;
    logic mode;
    logic [15:0] exp, got;
    logic [1:0] tail;
    int cyc, t_acq, t_conv, exp_cyc;
    ch = v[33:31]; mode = v[30]; conv_data = v[29:16]; exp = v[15:0];
    cs_n = 1'b1; sclk = 1'b0; wait_n(40);
    cs_n = 1'b0; wait_n(6);
    chk("R2 oe after cs fall", dout_oe, 1);
    chk("R2 dout low before result", dout, 0);
    send_cmd(ch, mode);
    chk("R4 channel after command", ch_sel, ch);
    if (!mode) begin
      chk("R5 acq after 8th edge", {acq, conv}, 2'b10);
      for (int j = 0; j < 4; j++) sclk_cycle(1'b0);
      chk("R5 conv after 12th edge", {acq, conv}, 2'b01);
      for (int j = 0; j < 4; j++) sclk_cycle(1'b0);
      chk("R5 idle after 16th edge", {acq, conv, eoc_n}, 3'b001);
      sclk = 1'b0; wait_n(H);
    end else begin
      sclk = 1'b0;
      cyc = 0; t_acq = -1; t_conv = -1;
      while (eoc_n && cyc < 500) begin
        @(negedge clk); cyc++;
        if (acq && t_acq < 0) t_acq = cyc;
        if (conv && t_conv < 0) t_conv = cyc;
      end
      exp_cyc = SYNC + 1 + START_DLY + 2 * OSC_HALF * (6 + INT_CONV) + 1 - H;
      chk("R8 eoc fall time in window",
          (cyc >= exp_cyc - 3 && cyc <= exp_cyc + 3), 1);
      chk("R8 acq precedes conv", (t_acq > 0 && t_conv > t_acq), 1);
      chk("R8 acq length", t_conv - t_acq, 2 * OSC_HALF * 4 + OSC_HALF);
      wait_n(1);
      chk("R8 MSB at eoc fall", dout, exp[15]);
    end
    for (int k = 0; k < 16; k++) begin
      got[15-k] = dout;
      sclk = 1'b1; wait_n(H);
      sclk = 1'b0; wait_n(H);
    end
    chk(mode ? "R6 frame local-clock mode" : "R6 frame serial-clock mode (R3)", got, exp);
    for (int k = 0; k < 2; k++) begin
      tail[k] = dout;
      sclk = 1'b1; wait_n(H);
      sclk = 1'b0; wait_n(H);
    end
    chk("R7 zeros after frame", tail, 2'b00);
    cs_n = 1'b1; wait_n(4);
    chk("R11 oe low with cs high", dout_oe, 0);
    chk("R9 eoc high after cs rise", eoc_n, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int v0;
    checks = 0; errs = 0; viol_cnt = 0; done = 0;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0; conv_data = '0;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);
    chk("R1 reset outputs", {dout_oe, eoc_n, acq, conv, dout}, 5'b01000);

    for (int n = 0; n < NV; n++) run_txn(VEC[n]);

    // R9 abort in serial-clock acquisition
    wait_n(40); cs_n = 1'b0; wait_n(6);
    send_cmd(3'd4, 1'b0);
    sclk_cycle(1'b0);
    chk("R9 acq before abort", acq, 1);
    cs_n = 1'b1; wait_n(4);
    chk("R9 abort drops strobes", {acq, conv, dout_oe}, 3'b000);
    for (int j = 0; j < 4; j++) sclk_cycle(1'b1);
    chk("R11 sclk with cs high keeps oe low", dout_oe, 0);

    // R9 abort in local-clock conversion
    sclk = 1'b0; wait_n(40); cs_n = 1'b0; wait_n(6);
    send_cmd(3'd3, 1'b1);
    sclk = 1'b0; wait_n(50);
    chk("R9 conv before abort", conv, 1);
    cs_n = 1'b1; wait_n(4);
    chk("R9 abort in conversion", {acq, conv, eoc_n}, 3'b001);
    wait_n(100);
    chk("R9 stays shut down", {eoc_n, dout_oe}, 2'b10);

    // R10 early cs fall
    v0 = viol_cnt;
    cs_n = 1'b0; wait_n(40);
    cs_n = 1'b1; wait_n(3);
    cs_n = 1'b0; wait_n(6);
    chk("R10 violation pulse", viol_cnt - v0, 1);
    chk("R10 early fall ignored", dout_oe, 0);
    for (int j = 0; j < 3; j++) sclk_cycle(1'b1);
    chk("R10 sclk ignored after early fall", {dout_oe, acq}, 2'b00);
    sclk = 1'b0; cs_n = 1'b1; wait_n(40);
    cs_n = 1'b0; wait_n(6);
    chk("R10 later fall accepted", dout_oe, 1);
    chk("R10 no violation on valid fall", viol_cnt - v0, 1);
    cs_n = 1'b1; wait_n(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule